// File: doc/BRIEF.md
# Software-Clocked Two-Wire Bus Master Port

This block gives a processor direct, bit-level control over the clock and data lines of an I2C bus. Software writes one control word that holds four bits. A mode bit chooses between master and slave operation. A clock-level bit sets the SCL line. A data-level bit sets the SDA line. A drive-enable bit decides whether the SDA driver is active at all. Software builds every START, address, data, acknowledge and STOP phase from a series of such writes. The block itself never sequences anything.

Both bus lines are open-drain. The block only reports when a line must be pulled low, and an external pull-up supplies the high level. The sampled SCL and SDA levels pass through a synchronizer. On each rising SCL edge seen after the synchronizer, the SDA level is latched into a data-in bit that software reads back. Reading that bit is how a receiving master collects data and acknowledge bits.

Top module: `i2cbb_master_port`

## Requirements
- R1: After reset the control word is mode=0, drive-enable=0, data-level=1 and clock-level=1. The data-in bit is 0 and neither bus line is pulled low.
- R2: While the mode bit is 0 (slave), neither SCL nor SDA is pulled low, whatever the other control bits hold.
- R3: While the mode bit is 1 (master), SCL is pulled low exactly when the clock-level bit is 0 and is released when it is 1.
- R4: While mode and drive-enable are both 1, SDA is pulled low exactly when the data-level bit is 0 and is released when it is 1.
- R5: While drive-enable is 0, SDA is never pulled low, so a receiving master leaves the line to the slave.
- R6: A write with `ctl_we` high loads all four bits at one clock edge: wdata[3]=mode, [2]=drive-enable, [1]=data-level, [0]=clock-level. Pins and readback reflect the new word after that single edge.
- R7: On a rising edge of synchronized SCL, the data-in bit takes the synchronized SDA level. It is readable within SYNC_STAGES+2 cycles of the SCL pin rising.
- R8: Between rising SCL edges, the data-in bit holds its value whatever SDA does.
- R9: A falling SCL edge does not change the data-in bit.
- R10: When `ctl_we` is low the control word keeps its value, whatever `ctl_wdata` carries.
- R11: `ctl_rdata` returns {data-in, mode, drive-enable, data-level, clock-level}, with data-in at bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word to load |
| ctl_rdata | output | 5 | Readback of data-in and the control word |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_pull_low | output | 1 | SCL open-drain pull-down enable |
| sda_pull_low | output | 1 | SDA open-drain pull-down enable |

## Verification
The bench runs through combinations of the control bits, including slave mode with every level bit at 0. A design that let slave mode drive a line would pull it low there. With drive-enable cleared and the data level at 0, a design that ignored the enable would show SDA held low. SDA is changed while SCL is held high and again across a falling SCL edge. A design that sampled the level continuously, or on both edges, would change data-in at those points. The bench also changes the write data while the strobe is low, to catch a register that loads when it should not.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;
   localparam int CTL_W  = 4;
   localparam int RD_W   = CTL_W + 1;

   typedef struct packed {
      logic mode;     // 1 = master
      logic drv_en;   // SDA driver enable
      logic dat_lvl;  // SDA level request
      logic clk_lvl;  // SCL level request
   } ctl_t;

   localparam ctl_t CTL_RESET = '{mode: 1'b0, drv_en: 1'b0, dat_lvl: 1'b1, clk_lvl: 1'b1};
endpackage

// File: rtl/i2cbb_sync.sv
module i2cbb_sync #(
   parameter int         WIDTH     = 2,
   parameter int         STAGES    = 2,
   parameter logic       RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cbb_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2cbb_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= {WIDTH{RESET_VAL}};
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= {WIDTH{RESET_VAL}};
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[LAST];
endmodule

// File: rtl/i2cbb_ctl_reg.sv
module i2cbb_ctl_reg
   import i2cbb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output ctl_t             ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl <= CTL_RESET;
      else if (we) ctl <= ctl_t'(wdata);
   end

   assert_load_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ctl == ctl_t'($past(wdata))));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(ctl));
endmodule

// File: rtl/i2cbb_rx_capture.sv
module i2cbb_rx_capture #(
   parameter logic DIN_RESET  = 1'b0,
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic din
);
   logic scl_prev;
   logic scl_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_prev <= IDLE_LEVEL;
      else        scl_prev <= scl_s;
   end

   assign scl_rise = scl_s & ~scl_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        din <= DIN_RESET;
      else if (scl_rise) din <= sda_s;
   end
endmodule

// File: rtl/i2cbb_pin_drive.sv
module i2cbb_pin_drive
   import i2cbb_pkg::*;
(
   input  ctl_t ctl,
   output logic scl_low,
   output logic sda_low
);
   always_comb begin
      scl_low = 1'b0;
      sda_low = 1'b0;
      if (ctl.mode) begin
         scl_low = ~ctl.clk_lvl;
         sda_low = ctl.drv_en & ~ctl.dat_lvl;
      end
   end
endmodule

// File: rtl/i2cbb_master_port.sv
module i2cbb_master_port
   import i2cbb_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic DIN_RESET   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [RD_W-1:0]  ctl_rdata,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             scl_pull_low,
   output logic             sda_pull_low
);
   ctl_t       ctl;
   logic [1:0] bus_s;
   logic       scl_s;
   logic       sda_s;
   logic       din;

   i2cbb_ctl_reg u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_we),
      .wdata (ctl_wdata),
      .ctl   (ctl)
   );

   i2cbb_pin_drive u_pins (
      .ctl     (ctl),
      .scl_low (scl_pull_low),
      .sda_low (sda_pull_low)
   );

   i2cbb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (bus_s)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   i2cbb_rx_capture #(.DIN_RESET(DIN_RESET), .IDLE_LEVEL(1'b1)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (scl_s),
      .sda_s (sda_s),
      .din   (din)
   );

   assign ctl_rdata = {din, ctl};

   assert_slave_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.mode |-> (!scl_pull_low && !sda_pull_low));

   assert_scl_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.mode |-> (scl_pull_low == !ctl.clk_lvl));

   assert_sda_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.mode && ctl.drv_en) |-> (sda_pull_low == !ctl.dat_lvl));

   assert_sda_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.drv_en |-> !sda_pull_low);

   assert_din_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (din != $past(din)) |-> ($past(scl_s) && !$past(scl_s, 2)));
endmodule

// File: tb/i2cbb_master_port_tb.sv
`timescale 1ns/1ps
module i2cbb_master_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [3:0] ctl_wdata = 4'h0;
   logic [4:0] ctl_rdata;
   logic       scl_pull_low, sda_pull_low;
   logic       ext_sda_low = 1'b0;
   logic       scl_i, sda_i;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   assign scl_i = ~scl_pull_low;
   assign sda_i = ~(sda_pull_low | ext_sda_low);

   i2cbb_master_port u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .scl_i(scl_i), .sda_i(sda_i),
      .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
   );

   // {mode, drv_en, dat_lvl, clk_lvl, exp_scl_low, exp_sda_low}
   localparam logic [5:0] VEC [10] = '{
      6'b1100_11, 6'b1101_01, 6'b1110_10, 6'b1111_00, 6'b1000_10,
      6'b1011_00, 6'b0100_00, 6'b0000_00, 6'b0110_00, 6'b1001_00
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] w);
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = w;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      // R1 reset state, R11 readback layout
      chk("R1 readback", {3'b0, ctl_rdata}, 8'h03);
      chk("R1 pins", {6'b0, scl_pull_low, sda_pull_low}, 8'h00);
      rst_n = 1'b1;
      idle(4);
      chk("R1 after release", {3'b0, ctl_rdata}, 8'h03);

      // R2 R3 R4 R5 R6 R11: vector table
      for (int v = 0; v < 10; v++) begin
         wr(VEC[v][5:2]);
         chk("R6 R11 ctl readback", {4'b0, ctl_rdata[3:0]}, {4'b0, VEC[v][5:2]});
         chk("R2 R3 R4 R5 pins", {6'b0, scl_pull_low, sda_pull_low}, {6'b0, VEC[v][1:0]});
      end

      // R10: write data changes with strobe low
      wr(4'b1111);
      @(negedge clk);
      ctl_wdata = 4'b0000;
      idle(3);
      chk("R10 hold", {4'b0, ctl_rdata[3:0]}, 8'h0F);
      chk("R10 pins", {6'b0, scl_pull_low, sda_pull_low}, 8'h00);

      // R7: receive a 1 then a 0 on rising SCL
      wr(4'b1010);                 // master, receive, SCL low
      ext_sda_low = 1'b0;
      idle(4);
      wr(4'b1011);                 // SCL released
      idle(4);
      chk("R7 capture 1", {7'b0, ctl_rdata[4]}, 8'h01);
      wr(4'b1010);
      ext_sda_low = 1'b1;
      idle(4);
      chk("R9 falling edge keeps", {7'b0, ctl_rdata[4]}, 8'h01);
      wr(4'b1011);
      idle(4);
      chk("R7 capture 0", {7'b0, ctl_rdata[4]}, 8'h00);

      // R8: SDA changes while SCL high
      ext_sda_low = 1'b0;
      idle(6);
      chk("R8 hold while high", {7'b0, ctl_rdata[4]}, 8'h00);

      // R9: falling edge with changed SDA
      wr(4'b1010);
      idle(6);
      chk("R9 no capture on fall", {7'b0, ctl_rdata[4]}, 8'h00);
      ext_sda_low = 1'b1;
      idle(6);
      chk("R8 hold while low", {7'b0, ctl_rdata[4]}, 8'h00);
      ext_sda_low = 1'b0;
      wr(4'b1011);
      idle(4);
      chk("R7 capture after low phase", {7'b0, ctl_rdata[4]}, 8'h01);

      // R1: reset again in master mode
      wr(4'b1100);
      rst_n = 1'b0;
      idle(2);
      chk("R1 re-reset", {3'b0, ctl_rdata}, 8'h03);
      chk("R1 re-reset pins", {6'b0, scl_pull_low, sda_pull_low}, 8'h00);
      finish_run();
   end
endmodule